// File: doc/BRIEF.md
# Push-Button Pulse-Width Adjuster

This block holds the pulse-width setting of a PWM generator and moves it up or down from two active-low push-buttons. Both button levels are brought into the clock domain through a two-stage synchroniser. A slow enable tick, typically 200 Hz, sets the pace. On each tick cycle the setting moves by one step in the direction of the button that is held. A full sweep across 1000 values therefore always takes the same time: 5 s at 200 Hz.

The setting never wraps around. Counting down stops at zero. Counting up stops at the limit input, which is the wave-period setting plus one, so the duty cycle stays between 0 and 100 percent. If the limit is lowered below the present setting, the setting is pulled down to the limit on the next clock edge. Debouncing of the buttons is done upstream and is not part of this block.

Top module: `duty_step_ctrl`

## Requirements
- R1: While `rst_n` is sampled low on a rising clock edge, `pw` is loaded with 0.
- R2: With the up button held (`btn_up_n` = 0) and the down button released, each clock cycle with `tick_en` = 1 raises `pw` by exactly 1.
- R3: With the down button held (`btn_dn_n` = 0) and the up button released, each clock cycle with `tick_en` = 1 lowers `pw` by exactly 1.
- R4: On cycles with `tick_en` = 0, `pw` does not change, whatever the buttons do, as long as `pw` does not exceed `limit`.
- R5: Counting up stops at `limit`. Further up ticks leave `pw` equal to `limit`.
- R6: Counting down stops at 0. Further down ticks leave `pw` at 0.
- R7: With both buttons held, tick cycles leave `pw` unchanged.
- R8: With both buttons released, tick cycles leave `pw` unchanged.
- R9: A button level acts only after two synchroniser stages. If a press is applied between edges while `tick_en` stays 1, `pw` is unchanged after the first and second rising edges and takes its first step at the third.
- R10: When `pw` exceeds `limit`, `pw` is loaded with `limit` on the next rising clock edge, whatever the state of the tick and the buttons.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Slow step enable, one clock wide per tick |
| btn_up_n | input | 1 | Up button level, active low, asynchronous |
| btn_dn_n | input | 1 | Down button level, active low, asynchronous |
| limit | input | 10 | Upper bound for the pulse-width setting |
| pw | output | 10 | Pulse-width setting |

## Verification
The hardest case to reach from the ports is the limit being lowered underneath a setting that has already climbed high. To get there, the stimulus first sweeps the setting up to its ceiling over about a thousand ticks. It then drops `limit` while the tick is low, and checks that the setting is pulled down on the very next edge rather than waiting for a tick. The two-stage latency is observed by raising the tick permanently in the same cycle as the press, then sampling after each of the first three edges.

// File: rtl/duty_pkg.sv
`timescale 1ns/1ps
// Shared types for the pulse-width adjuster.
// Assumes nothing beyond a 2-bit encoding of the step direction.
package duty_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_t;
endpackage

// File: rtl/btn_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for N asynchronous active-low button levels.
// Assumes inputs are already debounced; resets every stage to released (1).
module btn_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] sync_n
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_btn
        logic [STAGES-1:0] chain;

        // Shift the raw level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_n[b]};
            end
        end

        assign sync_n[b] = chain[LAST];
    end
endmodule

// File: rtl/step_decode.sv
`timescale 1ns/1ps
// Turns synchronised active-low button levels into a step direction.
// Assumes inputs are already in the clock domain; both pressed means hold.
module step_decode
    import duty_pkg::*;
(
    input  logic      up_n,
    input  logic      dn_n,
    output logic      up_held,
    output logic      dn_held,
    output step_dir_t dir
);
    assign up_held = ~up_n;
    assign dn_held = ~dn_n;

    // Pick the direction; conflicting or absent presses hold.
    always_comb begin
        unique case ({up_held, dn_held})
            2'b10:   dir = STEP_UP;
            2'b01:   dir = STEP_DOWN;
            default: dir = STEP_HOLD;
        endcase
    end
endmodule

// File: rtl/sat_counter.sv
`timescale 1ns/1ps
// Reversible counter that saturates at zero and at a run-time limit.
// Assumes the limit may change at any time; an over-limit count is clamped
// on the next edge regardless of the step enable.
module sat_counter
    import duty_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  step_dir_t    dir,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_nxt;

    // Work out the next count with clamping at both ends.
    always_comb begin
        count_nxt = count;
        if (count > limit) begin
            count_nxt = limit;
        end else if (step_en) begin
            unique case (dir)
                STEP_UP:   if (count < limit) count_nxt = count + ONE;
                STEP_DOWN: if (count != ZERO) count_nxt = count - ONE;
                default:   count_nxt = count;
            endcase
        end
    end

    // Register the count; reset loads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else begin
            count <= count_nxt;
        end
    end
endmodule

// File: rtl/duty_step_ctrl.sv
`timescale 1ns/1ps
// Pulse-width adjuster: two active-low buttons step a clamped counter once
// per slow tick. Assumes buttons are debounced upstream and tick_en is a
// single-cycle pulse at the sweep rate.
module duty_step_ctrl
    import duty_pkg::*;
#(
    parameter int W          = 10,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         btn_up_n,
    input  logic         btn_dn_n,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pw
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_sync_n;
    logic            up_held;
    logic            dn_held;
    step_dir_t       dir;

    btn_sync #(.N(NBTN), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  ({btn_dn_n, btn_up_n}),
        .sync_n (btn_sync_n)
    );

    step_decode u_dec (
        .up_n    (btn_sync_n[0]),
        .dn_n    (btn_sync_n[1]),
        .up_held (up_held),
        .dn_held (dn_held),
        .dir     (dir)
    );

    sat_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (tick_en),
        .dir     (dir),
        .limit   (limit),
        .count   (pw)
    );
endmodule

// File: rtl/duty_step_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the pulse-width adjuster, bound to the top module.
module duty_step_ctrl_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [W-1:0] limit,
    input logic [W-1:0] pw,
    input logic         up_held,
    input logic         dn_held
);
    // R4: no tick and in range means no change.
    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && pw <= limit) |=> $stable(pw));

    // R2/R3: a tick moves the count by at most one.
    p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && pw <= limit) |=>
        ({1'b0, pw} == {1'b0, $past(pw)} ||
         {1'b0, pw} == {1'b0, $past(pw)} + 1'b1 ||
         {1'b0, pw} + 1'b1 == {1'b0, $past(pw)}));

    // R5/R10: with a steady limit the count sits at or below it.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == $past(limit)) |-> (pw <= limit));

    // R6: counting down at zero stays at zero.
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pw == '0 && dn_held && !up_held) |=> (pw == '0));

    // R7: both buttons held means hold.
    p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_held && dn_held && pw <= limit) |=> $stable(pw));

    // R10: an over-limit count is clamped on the next edge.
    p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pw > limit) |=> (pw == $past(limit)));
endmodule

bind duty_step_ctrl duty_step_ctrl_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .limit   (limit),
    .pw      (pw),
    .up_held (up_held),
    .dn_held (dn_held)
);

// File: tb/duty_step_ctrl_tb_top.sv
`timescale 1ns/1ps
module duty_step_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       btn_up_n = 1'b1;
    logic       btn_dn_n = 1'b1;
    logic [9:0] limit = 10'd1000;
    logic [9:0] pw;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    duty_step_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .btn_up_n (btn_up_n),
        .btn_dn_n (btn_dn_n),
        .limit    (limit),
        .pw       (pw)
    );

    task automatic chk(input string req, input logic [9:0] exp);
        checks++;
        if (pw !== exp) begin
            errors++;
            $display("FAIL %s: pw=%0d expected %0d", req, pw, exp);
        end
    endtask

    // Set button levels and let them settle through the synchroniser.
    task automatic buttons(input logic up, input logic dn);
        @(negedge clk);
        btn_up_n = ~up;
        btn_dn_n = ~dn;
        repeat (3) @(negedge clk);
    endtask

    // Issue n single-cycle ticks.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        chk("R1 reset", 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 10'd0);
    endtask

    task automatic t_up_and_idle;
        buttons(1'b1, 1'b0);
        ticks(5);
        chk("R2 up five ticks", 10'd5);
        repeat (10) @(negedge clk);
        chk("R4 held without tick", 10'd5);
    endtask

    task automatic t_down;
        buttons(1'b0, 1'b1);
        ticks(3);
        chk("R3 down three ticks", 10'd2);
    endtask

    task automatic t_both_none;
        buttons(1'b1, 1'b1);
        ticks(4);
        chk("R7 both held", 10'd2);
        buttons(1'b0, 1'b0);
        ticks(4);
        chk("R8 none held", 10'd2);
    endtask

    task automatic t_floor;
        buttons(1'b0, 1'b1);
        ticks(10);
        chk("R6 floor at zero", 10'd0);
    endtask

    task automatic t_ceiling;
        @(negedge clk) limit = 10'd999;
        buttons(1'b1, 1'b0);
        ticks(999);
        chk("R5 reach limit", 10'd999);
        ticks(6);
        chk("R5 stay at limit", 10'd999);
    endtask

    task automatic t_limit_drop;
        buttons(1'b0, 1'b0);
        @(negedge clk) limit = 10'd300;
        @(negedge clk);
        chk("R10 clamp to lowered limit", 10'd300);
        @(negedge clk) limit = 10'd600;
        buttons(1'b1, 1'b0);
        ticks(2);
        chk("R10 resumes after clamp", 10'd302);
        buttons(1'b0, 1'b0);
    endtask

    task automatic t_sync_delay;
        @(negedge clk);
        btn_up_n = 1'b0;
        tick_en  = 1'b1;
        @(negedge clk);
        chk("R9 after first edge", 10'd302);
        @(negedge clk);
        chk("R9 after second edge", 10'd302);
        @(negedge clk);
        chk("R9 first step at third edge", 10'd303);
        tick_en  = 1'b0;
        btn_up_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_up_and_idle();
        t_down();
        t_both_none();
        t_floor();
        t_ceiling();
        t_limit_drop();
        t_sync_delay();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule